// File: doc/BRIEF.md
# Page-Cache Lookup Dispatcher

This block sits behind the lookup stage of a shared second-level translation cache. For every lookup it receives the outcome: the deepest level hit, whether that hit is a leaf, whether the entry showed an ECC error, and the kind of request. It also samples whether the upper-level walker and the last-level walker are free. From these it picks one destination. The choices are a response to the first-level TLB, the upper-level walker, the last-level walker, the hypervisor walker or the miss queue. A prefetch may also be dropped.

The chosen request is held in a single output register and offered on exactly one destination port. The ports use valid-ready handshakes. An ECC error is routed as a full miss, so a fresh walk starts from the top level. It also raises a one-cycle invalidate strobe that carries the request tag.

Top module: `pcd_dispatch`

## Requirements
- R1: After reset all `dst_valid_o` bits and `inval_o` are low, and `in_ready_o` is high.
- R2: Destination bit positions are: bit 0 first-level TLB response, bit 1 upper walker, bit 2 last-level walker, bit 3 hypervisor walker, bit 4 miss queue. Kind codes 0 (normal), 1 (first-stage only) and 6/7 (treated as normal) with an effective leaf hit go to bit 0.
- R3: Hit-level codes are 0 none, 1 1GB, 2 2MB, and 3 is treated as none. For a normal or first-stage-only request without an effective leaf hit, level 2 selects bit 2 if `llptw_free_i` is set, otherwise bit 4. Any other level selects bit 1 if `ptw_free_i` is set, otherwise bit 4.
- R4: Second-stage-only requests (kind 2) go to bit 0 on a leaf hit. Otherwise they go to bit 1 if the upper walker is free, else to bit 4.
- R5: Both-stage requests (kind 3) go to bit 1 on a first-stage leaf hit (bit 4 if the upper walker is busy). Otherwise they follow the R3 rule.
- R6: Hypervisor sub-requests (kind 4) go to bit 3 without a leaf hit. On a leaf hit they go to bit 1 when `src_ll_i` is 0 and to bit 2 when it is 1. They never reach bit 4.
- R7: Prefetch requests (kind 5) never reach bit 4. A leaf hit is dropped. A miss follows the R3 walker choice, but is dropped when that walker is busy. A dropped request raises no `dst_valid_o` bit.
- R8: With `ecc_err_i` set, the request is routed as a miss at level 0. One cycle after acceptance, `inval_o` is high for one cycle with `inval_tag_o` equal to the accepted tag.
- R9: A request accepted at a clock edge appears on exactly one `dst_valid_o` bit after that edge, with `tag_o` and `kind_o` equal to its inputs.
- R10: While the offered destination holds its ready low, `dst_valid_o`, `tag_o` and `kind_o` stay stable and `in_ready_o` is low.
- R11: When the offered destination is ready, `in_ready_o` is high in the same cycle, so one request per cycle can flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Lookup outcome valid |
| in_ready_o | output | 1 | Dispatcher can take a lookup outcome |
| hit_lvl_i | input | 2 | Deepest level hit (0 none, 1 1GB, 2 2MB) |
| leaf_i | input | 1 | Hit entry is a leaf |
| ecc_err_i | input | 1 | Hit entry failed its ECC check |
| kind_i | input | 3 | Request kind code |
| src_ll_i | input | 1 | Hypervisor sub-request came from the last-level walker |
| tag_i | input | TAG_W | Request tag |
| ptw_free_i | input | 1 | Upper-level walker can take a request |
| llptw_free_i | input | 1 | Last-level walker can take a request |
| dst_valid_o | output | 5 | One-hot destination valid |
| dst_ready_i | input | 5 | Destination ready, same bit order |
| tag_o | output | TAG_W | Tag of the offered request |
| kind_o | output | 3 | Kind of the offered request |
| inval_o | output | 1 | Invalidate strobe after an ECC error |
| inval_tag_o | output | TAG_W | Tag of the request to invalidate |

## Verification
Each routing result and the invalidate strobe are due one clock after the edge that accepts the lookup. With the destination ready, the output register is empty again one clock later. The bench drives inputs on the falling edge. It checks `in_ready_o` before the accepting edge, the one-hot destination, tag and strobe at the next falling edge, and an empty output at the one after that. This is done across every combination of kind, level, leaf, ECC, source and walker availability. A separate back-pressure run holds a destination not ready for several cycles and checks, at each falling edge, that the output is stable and no new lookup is taken.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int NDST = 5;
  localparam int DW   = 3;

  typedef enum logic [DW-1:0] {
    D_L1   = 3'd0,
    D_UP   = 3'd1,
    D_LL   = 3'd2,
    D_HYP  = 3'd3,
    D_MQ   = 3'd4,
    D_DROP = 3'd5
  } dest_e;

  typedef enum logic [2:0] {
    K_NORM = 3'd0,
    K_S1   = 3'd1,
    K_S2   = 3'd2,
    K_BOTH = 3'd3,
    K_HYP  = 3'd4,
    K_PF   = 3'd5
  } kind_e;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_1G   = 2'd1;
  localparam logic [1:0] LVL_2M   = 2'd2;
endpackage

// File: rtl/pcd_route.sv
module pcd_route
  import pcd_pkg::*;
(
  input  logic [1:0] hit_lvl_i,
  input  logic       leaf_i,
  input  logic       ecc_err_i,
  input  logic [2:0] kind_i,
  input  logic       src_ll_i,
  input  logic       ptw_free_i,
  input  logic       llptw_free_i,
  output dest_e      dest_o
);
  logic       hit;
  logic [1:0] lvl;
  logic       need_ll;
  logic       walker_free;
  dest_e      walker;

  // ECC error: entry discarded, restart walk from the top
  assign hit  = leaf_i & ~ecc_err_i;
  assign lvl  = (ecc_err_i || hit_lvl_i == 2'd3) ? LVL_NONE : hit_lvl_i;
  assign need_ll     = (lvl == LVL_2M);
  assign walker      = need_ll ? D_LL : D_UP;
  assign walker_free = need_ll ? llptw_free_i : ptw_free_i;

  always_comb begin
    unique case (kind_i)
      K_HYP:   dest_o = hit ? (src_ll_i ? D_LL : D_UP) : D_HYP;
      K_PF:    dest_o = (hit || !walker_free) ? D_DROP : walker;
      K_S2:    dest_o = hit ? D_L1 : (ptw_free_i ? D_UP : D_MQ);
      K_BOTH:  dest_o = hit ? (ptw_free_i ? D_UP : D_MQ)
                            : (walker_free ? walker : D_MQ);
      default: dest_o = hit ? D_L1 : (walker_free ? walker : D_MQ);
    endcase
  end
endmodule

// File: rtl/pcd_hold.sv
module pcd_hold
  import pcd_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  dest_e            in_dest_i,
  input  logic [TAG_W-1:0] in_tag_i,
  input  logic [2:0]       in_kind_i,
  output logic [NDST-1:0]  dst_valid_o,
  input  logic [NDST-1:0]  dst_ready_i,
  output logic [TAG_W-1:0] tag_o,
  output logic [2:0]       kind_o
);
  logic             full_q;
  dest_e            dest_q;
  logic [TAG_W-1:0] tag_q;
  logic [2:0]       kind_q;
  logic             drain;
  logic             load;

  for (genvar g = 0; g < NDST; g++) begin : g_dst
    assign dst_valid_o[g] = full_q && (dest_q == DW'(g));
  end

  assign drain      = |(dst_valid_o & dst_ready_i);
  assign in_ready_o = !full_q || drain;
  assign load       = in_valid_i && in_ready_o && (in_dest_i != D_DROP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      dest_q <= D_L1;
      tag_q  <= '0;
      kind_q <= '0;
    end else begin
      if (load) begin
        full_q <= 1'b1;
        dest_q <= in_dest_i;
        tag_q  <= in_tag_i;
        kind_q <= in_kind_i;
      end else if (drain) begin
        full_q <= 1'b0;
      end
    end
  end

  assign tag_o  = tag_q;
  assign kind_o = kind_q;
endmodule

// File: rtl/pcd_dispatch.sv
module pcd_dispatch
  import pcd_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       hit_lvl_i,
  input  logic             leaf_i,
  input  logic             ecc_err_i,
  input  logic [2:0]       kind_i,
  input  logic             src_ll_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             ptw_free_i,
  input  logic             llptw_free_i,
  output logic [4:0]       dst_valid_o,
  input  logic [4:0]       dst_ready_i,
  output logic [TAG_W-1:0] tag_o,
  output logic [2:0]       kind_o,
  output logic             inval_o,
  output logic [TAG_W-1:0] inval_tag_o
);
  dest_e            dest;
  logic             inval_q;
  logic [TAG_W-1:0] inval_tag_q;

  pcd_route u_route (
    .hit_lvl_i    (hit_lvl_i),
    .leaf_i       (leaf_i),
    .ecc_err_i    (ecc_err_i),
    .kind_i       (kind_i),
    .src_ll_i     (src_ll_i),
    .ptw_free_i   (ptw_free_i),
    .llptw_free_i (llptw_free_i),
    .dest_o       (dest)
  );

  pcd_hold #(.TAG_W(TAG_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_dest_i   (dest),
    .in_tag_i    (tag_i),
    .in_kind_i   (kind_i),
    .dst_valid_o (dst_valid_o),
    .dst_ready_i (dst_ready_i),
    .tag_o       (tag_o),
    .kind_o      (kind_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inval_q     <= 1'b0;
      inval_tag_q <= '0;
    end else begin
      inval_q <= in_valid_i && in_ready_o && ecc_err_i;
      if (in_valid_i && in_ready_o && ecc_err_i) inval_tag_q <= tag_i;
    end
  end

  assign inval_o     = inval_q;
  assign inval_tag_o = inval_tag_q;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int TAG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             leaf_i,
  input logic             ecc_err_i,
  input logic [2:0]       kind_i,
  input logic [TAG_W-1:0] tag_i,
  input logic [4:0]       dst_valid_o,
  input logic [4:0]       dst_ready_i,
  input logic [TAG_W-1:0] tag_o,
  input logic             inval_o,
  input logic [TAG_W-1:0] inval_tag_o
);
  logic acc, stall;
  assign acc   = in_valid_i && in_ready_o;
  assign stall = (|dst_valid_o) && !(|(dst_valid_o & dst_ready_i));

  a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dst_valid_o));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> $stable(dst_valid_o) && $stable(tag_o));

  a_r10_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |-> !in_ready_o);

  a_r11_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(dst_valid_o & dst_ready_i)) |-> in_ready_o);

  a_r6_hyp_no_mq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && kind_i == 3'd4) |=> !dst_valid_o[4]);

  a_r7_pf_no_mq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && kind_i == 3'd5) |=> !dst_valid_o[4]);

  a_r2_leaf_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && kind_i == 3'd0 && leaf_i && !ecc_err_i) |=> dst_valid_o[0]);

  a_r8_inval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ecc_err_i) |=> inval_o && inval_tag_o == $past(tag_i));

  a_r8_inval_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && ecc_err_i) |=> !inval_o);
endmodule

bind pcd_dispatch pcd_checker #(.TAG_W(TAG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .leaf_i      (leaf_i),
  .ecc_err_i   (ecc_err_i),
  .kind_i      (kind_i),
  .tag_i       (tag_i),
  .dst_valid_o (dst_valid_o),
  .dst_ready_i (dst_ready_i),
  .tag_o       (tag_o),
  .inval_o     (inval_o),
  .inval_tag_o (inval_tag_o)
);

// File: tb/sim_pcd_dispatch.sv
`timescale 1ns/1ps
module sim_pcd_dispatch;
  localparam int TAG_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [1:0]       hit_lvl_i = '0;
  logic             leaf_i = 1'b0;
  logic             ecc_err_i = 1'b0;
  logic [2:0]       kind_i = '0;
  logic             src_ll_i = 1'b0;
  logic [TAG_W-1:0] tag_i = '0;
  logic             ptw_free_i = 1'b1;
  logic             llptw_free_i = 1'b1;
  logic [4:0]       dst_valid_o;
  logic [4:0]       dst_ready_i = '1;
  logic [TAG_W-1:0] tag_o;
  logic [2:0]       kind_o;
  logic             inval_o;
  logic [TAG_W-1:0] inval_tag_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pcd_dispatch #(.TAG_W(TAG_W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // 0 L1, 1 upper, 2 last-level, 3 hyp, 4 miss queue, 5 drop
  function automatic int exp_dest(int k, int lvl, int lf, int ecc, int src, int pf, int lfree);
    int  l;
    bit  hit;
    int  wk;
    bit  wf;
    hit = (lf == 1) && (ecc == 0);
    l   = (ecc == 1 || lvl == 3) ? 0 : lvl;
    wk  = (l == 2) ? 2 : 1;
    wf  = (l == 2) ? (lfree == 1) : (pf == 1);
    case (k)
      4: return hit ? (src == 1 ? 2 : 1) : 3;
      5: return (hit || !wf) ? 5 : wk;
      2: return hit ? 0 : (pf == 1 ? 1 : 4);
      3: return hit ? (pf == 1 ? 1 : 4) : (wf ? wk : 4);
      default: return hit ? 0 : (wf ? wk : 4);
    endcase
  endfunction

  function automatic string rtag(int k, int ecc);
    if (ecc == 1) return "R8";
    case (k)
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(dst_valid_o == 0, "R1 valid", dst_valid_o, 0);
    chk(in_ready_o == 1, "R1 ready", in_ready_o, 1);
    chk(inval_o == 0, "R1 inval", inval_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dst_valid_o == 0 && in_ready_o, "R1 after release", dst_valid_o, 0);

    // sweep
    for (int k = 0; k < 8; k++)
      for (int lvl = 0; lvl < 4; lvl++)
        for (int lf = 0; lf < 2; lf++)
          for (int ecc = 0; ecc < 2; ecc++)
            for (int src = 0; src < 2; src++)
              for (int pf = 0; pf < 2; pf++)
                for (int lfr = 0; lfr < 2; lfr++) begin
                  int d;
                  logic [4:0] ev;
                  string rq;
                  d  = exp_dest(k, lvl, lf, ecc, src, pf, lfr);
                  ev = (d < 5) ? 5'(1 << d) : 5'd0;
                  rq = ((k == 0 || k == 1 || k >= 6) && d == 0) ? "R2" : rtag(k, ecc);
                  in_valid_i = 1; kind_i = 3'(k); hit_lvl_i = 2'(lvl);
                  leaf_i = lf[0]; ecc_err_i = ecc[0]; src_ll_i = src[0];
                  ptw_free_i = pf[0]; llptw_free_i = lfr[0]; tag_i = 8'(n);
                  chk(in_ready_o == 1, "R11 ready idle", in_ready_o, 1);
                  @(negedge clk_i);
                  in_valid_i = 0;
                  chk(dst_valid_o == ev, rq, dst_valid_o, ev);
                  if (d < 5) begin
                    chk(tag_o == 8'(n) && kind_o == 3'(k), "R9 payload", tag_o, n & 8'hff);
                  end
                  chk(inval_o == ecc[0], "R8 strobe", inval_o, ecc);
                  if (ecc == 1) chk(inval_tag_o == 8'(n), "R8 tag", inval_tag_o, n & 8'hff);
                  @(negedge clk_i);
                  chk(dst_valid_o == 0 && inval_o == 0, "R9 drained", dst_valid_o, 0);
                  n++;
                end

    // back-pressure: normal leaf hit to L1 with L1 not ready
    dst_ready_i = 5'b11110;
    in_valid_i = 1; kind_i = 0; hit_lvl_i = 2; leaf_i = 1; ecc_err_i = 0;
    ptw_free_i = 1; llptw_free_i = 1; tag_i = 8'hA5;
    @(negedge clk_i);
    // second request: s2-only miss to upper walker
    kind_i = 2; leaf_i = 0; hit_lvl_i = 0; tag_i = 8'h3C;
    for (int c = 0; c < 4; c++) begin
      chk(dst_valid_o == 5'b00001, "R10 valid held", dst_valid_o, 1);
      chk(tag_o == 8'hA5, "R10 tag held", tag_o, 8'hA5);
      chk(in_ready_o == 0, "R10 not ready", in_ready_o, 0);
      @(negedge clk_i);
    end
    dst_ready_i = 5'b11111;
    #0.5;
    chk(in_ready_o == 1, "R11 pass-through", in_ready_o, 1);
    @(negedge clk_i);
    in_valid_i = 0;
    chk(dst_valid_o == 5'b00010, "R11 back-to-back dest", dst_valid_o, 2);
    chk(tag_o == 8'h3C, "R11 back-to-back tag", tag_o, 8'h3C);
    @(negedge clk_i);
    chk(dst_valid_o == 0, "R11 empty", dst_valid_o, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule